// File: doc/BRIEF.md
# Software-Filled Data Address Translation Buffer

This block translates data virtual addresses to physical addresses through a 64-entry, fully associative table that software fills and maintains itself. Software first stages a page-table entry by writing it to a holding register. It then writes the virtual address tag, which commits the staged entry into the slot chosen by a wrapping fill pointer. The entry is tagged with the current address-space number, and it may be marked global so that it matches in every address space. Software can drop every entry, or only the entries that are not global. It can also step through the table with a pointer-advancing read that copies one entry into a temporary register for inspection.

The lookup side is combinational. When a lookup does not hit, the block raises a miss flag. It also records the faulting virtual address and a status word built from instruction bits supplied with the lookup. The recorded fault stays frozen against later misses until software reads the captured address.

Top module: `dxlat_top`

## Requirements
- R1: After reset, no entry hits, the status, fault-address and temporary read values are 0, the fault capture is unlocked, and the first fill after reset goes to entry 0.
- R2: A write with select 1 only loads the staging register and leaves lookups unchanged. A write with select 2 fills the entry at the pointer with tag = data[42:13], using the staged entry and the current address-space number, marks it valid, and advances the pointer. The pointer wraps from 63 to 0, so the 65th fill overwrites entry 0.
- R3: A stored entry word is 40 bits: [1:0] = staged bits 2:1, [9:2] = staged bits 15:8, [12:10] = 0, [39:13] = staged bits 58:32 (the frame number). On a hit the physical address is {frame, VA[12:0]}. When there is no hit the physical address output is 0.
- R4: A write with select 0 sets the current address-space number to data[63:57]. An entry hits only when it is valid, its tag equals VA[42:13], and either its global flag (staged bit 4) is set or its stored number equals the current one.
- R5: When several entries match, the translation comes from the lowest-numbered matching entry.
- R6: A write with select 3 invalidates every entry and returns the pointer to 0.
- R7: A write with select 4 invalidates only the entries whose global flag is 0. Global entries keep hitting.
- R8: A read with select 0 returns 0, copies the entry word at the pointer into the temporary register, and advances the pointer. A read with select 1 returns the temporary register, zero-extended.
- R9: A lookup (lookup valid high) that misses while the capture is unlocked records VA[42:0] and a status of ({ibits, 6'b0} | 0x11), and then locks. A read with select 2 returns the status and a read with select 3 returns the recorded address, both zero-extended.
- R10: While the capture is locked, further misses change neither recorded value. A read with select 3 unlocks it, so the next miss is recorded.
- R11: Writes with selects 5, 6 and 7 have no effect on the entries, the pointer or the address-space number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0 number, 1 stage, 2 tag/fill, 3 drop all, 4 drop non-global |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 2 | Read target: 0 stepping read, 1 temporary, 2 status, 3 fault address |
| rd_data_o | output | 64 | Read data, 0 when no read is active |
| lk_valid_i | input | 1 | Lookup request qualifier |
| lk_va_i | input | 43 | Lookup virtual address |
| lk_ibits_i | input | 11 | Instruction bits recorded on a miss |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup request that missed |
| lk_pa_o | output | 40 | Translated physical address |

## Verification
The assertions assume that a stepping read never falls in the same cycle as a tag fill or a drop-all, since the block resolves that overlap in a fixed way that no requirement states. They also assume that the lookup qualifier is the only thing that turns a non-hit into a recorded miss. The bench drives register writes, register reads and lookups from separate tasks that each own whole cycles and never overlap. Each lookup is held across one edge, so the miss capture and the lock behave as they would under a real request stream.

// File: rtl/dxlat_pkg.sv
package dxlat_pkg;
  localparam int OFS_W  = 13;
  localparam int TAG_W  = 30;
  localparam int PFN_W  = 27;
  localparam int ASN_W  = 7;
  localparam int WORD_W = 40;
  localparam int IB_W   = 11;
  localparam int STAT_W = IB_W + 6;
  localparam int VA_W   = OFS_W + TAG_W;
  localparam int PA_W   = OFS_W + PFN_W;

  typedef enum logic [2:0] {
    WSEL_ASN  = 3'd0,
    WSEL_PTE  = 3'd1,
    WSEL_TAG  = 3'd2,
    WSEL_INVA = 3'd3,
    WSEL_INVP = 3'd4
  } wsel_e;

  typedef enum logic [1:0] {
    RSEL_STEP = 2'd0,
    RSEL_TEMP = 2'd1,
    RSEL_STAT = 2'd2,
    RSEL_FVA  = 2'd3
  } rsel_e;

  // compress a page-table entry into the stored entry word
  function automatic logic [WORD_W-1:0] pack_entry(input logic [63:0] pte);
    return {pte[58:32], 3'b000, pte[15:8], pte[2:1]};
  endfunction

  function automatic logic [PA_W-1:0] form_pa(input logic [WORD_W-1:0] w,
                                              input logic [OFS_W-1:0] ofs);
    return {w[WORD_W-1 -: PFN_W], ofs};
  endfunction

  function automatic logic [STAT_W-1:0] form_status(input logic [IB_W-1:0] ib);
    return {ib, 6'b000000} | STAT_W'(17'h11);
  endfunction
endpackage

// File: rtl/dxlat_ctrl.sv
module dxlat_ctrl
  import dxlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              asn_wr_i,
  input  logic              pte_wr_i,
  input  logic              tag_wr_i,
  input  logic              inv_all_i,
  input  logic              step_rd_i,
  input  logic [63:0]       data_i,
  input  logic [WORD_W-1:0] ptr_word_i,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [WORD_W-1:0] stage_word_o,
  output logic              stage_glob_o,
  output logic [ASN_W-1:0]  cur_asn_o,
  output logic [WORD_W-1:0] temp_o
);
  logic [IDX_W-1:0]  ptr_q;
  logic [WORD_W-1:0] stage_q, temp_q;
  logic              glob_q;
  logic [ASN_W-1:0]  asn_q;
  logic              ptr_adv;

  assign ptr_adv = tag_wr_i | step_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      stage_q <= '0;
      glob_q  <= 1'b0;
      asn_q   <= '0;
      temp_q  <= '0;
    end else begin
      if (inv_all_i)    ptr_q <= '0;
      else if (ptr_adv) ptr_q <= ptr_q + 1'b1;
      if (pte_wr_i) begin
        stage_q <= pack_entry(data_i);
        glob_q  <= data_i[4];
      end
      if (asn_wr_i)  asn_q  <= data_i[63:57];
      if (step_rd_i) temp_q <= ptr_word_i;
    end
  end

  assign ptr_o        = ptr_q;
  assign stage_word_o = stage_q;
  assign stage_glob_o = glob_q;
  assign cur_asn_o    = asn_q;
  assign temp_o       = temp_q;

  // R2
  fill_ptr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_wr_i && !inv_all_i) |=> ptr_q == IDX_W'($past(ptr_q) + 1'b1));
  // R6
  inv_ptr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> ptr_q == '0);
  // R8
  step_ptr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_rd_i && !tag_wr_i && !inv_all_i) |=> ptr_q == IDX_W'($past(ptr_q) + 1'b1));
endmodule

// File: rtl/dxlat_array.sv
module dxlat_array
  import dxlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [WORD_W-1:0] fill_word_i,
  input  logic              fill_glob_i,
  input  logic [ASN_W-1:0]  fill_asn_i,
  input  logic              inv_all_i,
  input  logic              inv_proc_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  input  logic [ASN_W-1:0]  cur_asn_i,
  input  logic [IDX_W-1:0]  peek_idx_i,
  output logic [WORD_W-1:0] peek_word_o,
  output logic              hit_o,
  output logic [WORD_W-1:0] hit_word_o
);
  logic [ENTRIES-1:0] valid_q, glob_q, match_vec;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [WORD_W-1:0]  word_q [ENTRIES];
  logic [ASN_W-1:0]   asn_q  [ENTRIES];
  logic [IDX_W-1:0]   hit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      glob_q  <= '0;
    end else if (inv_all_i) begin
      valid_q <= '0;
    end else if (inv_proc_i) begin
      valid_q <= valid_q & glob_q;
    end else if (fill_i) begin
      valid_q[fill_idx_i] <= 1'b1;
      glob_q[fill_idx_i]  <= fill_glob_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !inv_all_i && !inv_proc_i) begin
      tag_q[fill_idx_i]  <= fill_tag_i;
      word_q[fill_idx_i] <= fill_word_i;
      asn_q[fill_idx_i]  <= fill_asn_i;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = valid_q[e] && (tag_q[e] == look_tag_i) &&
                          (glob_q[e] || (asn_q[e] == cur_asn_i));
  end

  // lowest-numbered match wins
  always_comb begin
    hit_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match_vec[e]) hit_idx = IDX_W'(e);
    end
  end

  assign hit_o       = |match_vec;
  assign hit_word_o  = word_q[hit_idx];
  assign peek_word_o = word_q[peek_idx_i];

  // R6
  inv_all_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> valid_q == '0);
  // R7
  inv_proc_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_proc_i && !inv_all_i) |=> (valid_q & ~glob_q) == '0);
  // R2
  fill_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !inv_all_i && !inv_proc_i) |=> valid_q[$past(fill_idx_i)]);
endmodule

// File: rtl/dxlat_fault.sv
module dxlat_fault
  import dxlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [IB_W-1:0]   ibits_i,
  input  logic              unlock_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [VA_W-1:0]   fva_o,
  output logic              locked_o
);
  logic [STAT_W-1:0] stat_q;
  logic [VA_W-1:0]   fva_q;
  logic              lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      fva_q  <= '0;
      lock_q <= 1'b0;
    end else if (lock_q) begin
      if (unlock_i) lock_q <= 1'b0;
    end else if (miss_i) begin
      lock_q <= 1'b1;
      fva_q  <= va_i;
      stat_q <= form_status(ibits_i);
    end
  end

  assign stat_o   = stat_q;
  assign fva_o    = fva_q;
  assign locked_o = lock_q;

  // R9
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !lock_q) |=> lock_q && fva_q == $past(va_i));
  // R10
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !unlock_i) |=> lock_q && $stable(fva_q) && $stable(stat_q));
  // R10
  unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && unlock_i) |=> !lock_q);
endmodule

// File: rtl/dxlat_top.sv
module dxlat_top
  import dxlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_sel_i,
  input  logic [63:0] wr_data_i,
  input  logic        rd_en_i,
  input  logic [1:0]  rd_sel_i,
  output logic [63:0] rd_data_o,
  input  logic        lk_valid_i,
  input  logic [42:0] lk_va_i,
  input  logic [10:0] lk_ibits_i,
  output logic        lk_hit_o,
  output logic        lk_miss_o,
  output logic [39:0] lk_pa_o
);
  logic asn_wr, pte_wr, tag_wr, inv_all, inv_proc, step_rd, unlock;
  logic [IDX_W-1:0]  ptr;
  logic [WORD_W-1:0] stage_word, temp_word, peek_word, hit_word;
  logic              stage_glob, hit, locked;
  logic [ASN_W-1:0]  cur_asn;
  logic [STAT_W-1:0] stat;
  logic [VA_W-1:0]   fva;

  assign asn_wr   = wr_en_i && (wr_sel_i == WSEL_ASN);
  assign pte_wr   = wr_en_i && (wr_sel_i == WSEL_PTE);
  assign tag_wr   = wr_en_i && (wr_sel_i == WSEL_TAG);
  assign inv_all  = wr_en_i && (wr_sel_i == WSEL_INVA);
  assign inv_proc = wr_en_i && (wr_sel_i == WSEL_INVP);
  assign step_rd  = rd_en_i && (rd_sel_i == RSEL_STEP);
  assign unlock   = rd_en_i && (rd_sel_i == RSEL_FVA);

  dxlat_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk_i, .rst_ni,
    .asn_wr_i(asn_wr), .pte_wr_i(pte_wr), .tag_wr_i(tag_wr),
    .inv_all_i(inv_all), .step_rd_i(step_rd), .data_i(wr_data_i),
    .ptr_word_i(peek_word), .ptr_o(ptr), .stage_word_o(stage_word),
    .stage_glob_o(stage_glob), .cur_asn_o(cur_asn), .temp_o(temp_word)
  );

  dxlat_array #(.ENTRIES(ENTRIES)) array_i (
    .clk_i, .rst_ni,
    .fill_i(tag_wr), .fill_idx_i(ptr), .fill_tag_i(wr_data_i[42:13]),
    .fill_word_i(stage_word), .fill_glob_i(stage_glob), .fill_asn_i(cur_asn),
    .inv_all_i(inv_all), .inv_proc_i(inv_proc),
    .look_tag_i(lk_va_i[42:13]), .cur_asn_i(cur_asn),
    .peek_idx_i(ptr), .peek_word_o(peek_word),
    .hit_o(hit), .hit_word_o(hit_word)
  );

  assign lk_hit_o  = hit;
  assign lk_miss_o = lk_valid_i && !hit;
  assign lk_pa_o   = hit ? form_pa(hit_word, lk_va_i[OFS_W-1:0]) : '0;

  dxlat_fault fault_i (
    .clk_i, .rst_ni,
    .miss_i(lk_miss_o), .va_i(lk_va_i), .ibits_i(lk_ibits_i),
    .unlock_i(unlock), .stat_o(stat), .fva_o(fva), .locked_o(locked)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      unique case (rd_sel_i)
        RSEL_STEP: rd_data_o = '0;
        RSEL_TEMP: rd_data_o = 64'(temp_word);
        RSEL_STAT: rd_data_o = 64'(stat);
        default:   rd_data_o = 64'(fva);
      endcase
    end
  end

  // R9
  miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lk_miss_o, lk_hit_o && lk_valid_i}));
  // R9
  miss_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o |=> locked);
  // R3
  pa_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_pa_o[OFS_W-1:0] == lk_va_i[OFS_W-1:0]);
endmodule

// File: tb/dxlat_top_tb.sv
`timescale 1ns/1ps
module dxlat_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic        lk_valid = 1'b0;
  logic [42:0] lk_va = '0;
  logic [10:0] lk_ibits = '0;
  logic        lk_hit, lk_miss;
  logic [39:0] lk_pa;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dxlat_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_ibits_i(lk_ibits),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_pa_o(lk_pa)
  );

  typedef struct packed {
    logic [29:0] vpn;
    logic [26:0] pfn;
    logic        glob;
    logic [6:0]  asn;
    logic [12:0] ofs;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{30'h0000_0001, 27'h000_0001, 1'b0, 7'd5,   13'h0000},
    '{30'h0000_02A5, 27'h7FF_FFFF, 1'b1, 7'd5,   13'h1FFF},
    '{30'h3FFF_FFFF, 27'h0AB_CDEF, 1'b0, 7'd9,   13'h0123},
    '{30'h0000_0000, 27'h555_5555, 1'b0, 7'd0,   13'h0FED},
    '{30'h0123_4567, 27'h2AA_AAAA, 1'b1, 7'd127, 13'h1001},
    '{30'h2000_0000, 27'h000_0F0F, 1'b0, 7'd1,   13'h0002}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // page-table entry with chosen frame and global flag; bits 2:1 = 11, bits 15:8 = 3C
  function automatic logic [63:0] mk_pte(input logic [26:0] pfn, input logic g);
    return {5'b0, pfn, 16'h0000, 8'h3C, 1'b0, 2'b10, g, 4'b0110};
  endfunction

  function automatic logic [39:0] pack_ref(input logic [63:0] p);
    logic [39:0] r;
    r = '0;
    r[39:13] = p[58:32];
    r[9:2]   = p[15:8];
    r[1:0]   = p[2:1];
    return r;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic look(input logic [42:0] va, input logic [10:0] ib,
                      output logic h, output logic [39:0] pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_ibits = ib;
    #1 h = lk_hit; pa = lk_pa;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic set_asn(input logic [6:0] a);
    wr(3'd0, {a, 57'h1_2345_6789_ABCD});
  endtask

  task automatic fill(input logic [29:0] vpn, input logic [26:0] pfn, input logic g);
    wr(3'd1, mk_pte(pfn, g));
    wr(3'd2, {21'h1F_FFFF, vpn, 13'h1ABC});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic h;
    logic [39:0] pa;
    logic [63:0] pteA, pteB;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(2'd2, d); chk("R1 status", d, 64'd0);
    rd(2'd3, d); chk("R1 fault va", d, 64'd0);
    rd(2'd1, d); chk("R1 temp", d, 64'd0);
    look(43'd0, 11'd0, h, pa); chk("R1 no hit", {63'd0, h}, 64'd0);
    chk("R1 pa zero on miss", {24'd0, pa}, 64'd0);

    // R1/R2 wrap: first fill after reset is entry 0, 65th fill overwrites it
    set_asn(7'd0);
    for (int i = 0; i < 64; i++) fill(30'(1000 + i), 27'(i + 1), 1'b0);
    fill(30'd5000, 27'd77, 1'b0);
    look({30'd1000, 13'h0}, 11'd0, h, pa); chk("R2 wrap overwrote entry 0", {63'd0, h}, 64'd0);
    look({30'd5000, 13'h5}, 11'd0, h, pa); chk("R2 wrap new entry", {24'd0, pa}, {24'd0, 27'd77, 13'h5});
    look({30'd1001, 13'h9}, 11'd0, h, pa); chk("R2 entry 1 kept", {24'd0, pa}, {24'd0, 27'd2, 13'h9});

    // R2 staging write alone changes nothing
    wr(3'd1, mk_pte(27'h1234, 1'b1));
    look({30'd1001, 13'h9}, 11'd0, h, pa); chk("R2 stage only", {24'd0, pa}, {24'd0, 27'd2, 13'h9});

    // table walk: R3/R4 translation and address-space matching
    wr(3'd3, 64'd0);
    for (int i = 0; i < NV; i++) begin
      set_asn(VECS[i].asn);
      fill(VECS[i].vpn, VECS[i].pfn, VECS[i].glob);
    end
    for (int i = 0; i < NV; i++) begin
      set_asn(VECS[i].asn);
      look({VECS[i].vpn, VECS[i].ofs}, 11'd0, h, pa);
      chk("R4 own asn hit", {63'd0, h}, 64'd1);
      chk("R3 pa", {24'd0, pa}, {24'd0, VECS[i].pfn, VECS[i].ofs});
      set_asn(VECS[i].asn ^ 7'h40);
      look({VECS[i].vpn, VECS[i].ofs}, 11'd0, h, pa);
      chk("R4 other asn hit iff global", {63'd0, h}, {63'd0, VECS[i].glob});
    end

    // R5 lowest index wins
    wr(3'd3, 64'd0);
    set_asn(7'd3);
    fill(30'h777, 27'hAAA, 1'b0);
    fill(30'h777, 27'hBBB, 1'b1);
    look({30'h777, 13'h10}, 11'd0, h, pa); chk("R5 lowest match", {24'd0, pa}, {24'd0, 27'hAAA, 13'h10});
    set_asn(7'd4);
    look({30'h777, 13'h10}, 11'd0, h, pa); chk("R5 skip non-matching", {24'd0, pa}, {24'd0, 27'hBBB, 13'h10});

    // R11 unused write selects
    wr(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    set_asn(7'd3);
    look({30'h777, 13'h11}, 11'd0, h, pa); chk("R11 entries kept", {24'd0, pa}, {24'd0, 27'hAAA, 13'h11});
    wr(3'd5, 64'd0);
    look({30'h777, 13'h11}, 11'd0, h, pa); chk("R11 asn kept", {24'd0, pa}, {24'd0, 27'hAAA, 13'h11});

    // R7 drop non-global only
    wr(3'd3, 64'd0);
    set_asn(7'd2);
    fill(30'h100, 27'h11, 1'b0);
    fill(30'h200, 27'h22, 1'b1);
    wr(3'd4, 64'd0);
    look({30'h100, 13'h0}, 11'd0, h, pa); chk("R7 non-global dropped", {63'd0, h}, 64'd0);
    look({30'h200, 13'h3}, 11'd0, h, pa); chk("R7 global kept", {24'd0, pa}, {24'd0, 27'h22, 13'h3});

    // R6 drop all
    wr(3'd3, 64'd0);
    look({30'h200, 13'h3}, 11'd0, h, pa); chk("R6 all dropped", {63'd0, h}, 64'd0);

    // R8 stepping read and temporary register
    pteA = 64'h07FF_FFFF_0000_A5F6;
    pteB = mk_pte(27'h3C3_C3C3, 1'b0);
    wr(3'd1, pteA); wr(3'd2, {30'h55, 13'h0});
    wr(3'd3, 64'd0);
    rd(2'd0, d); chk("R8 step read returns 0", d, 64'd0);
    rd(2'd1, d); chk("R8 temp holds entry 0", d, {24'd0, pack_ref(pteA)});
    chk("R3 packed fields", d, {24'd0, 27'h7FF_FFFF, 3'b000, 8'hA5, 2'b11});
    wr(3'd1, pteB); wr(3'd2, {30'h66, 13'h0});
    wr(3'd3, 64'd0);
    rd(2'd0, d); rd(2'd0, d);
    rd(2'd1, d); chk("R8 pointer advanced to entry 1", d, {24'd0, pack_ref(pteB)});

    // R9/R10 fault capture and lock
    wr(3'd3, 64'd0);
    rd(2'd3, d);
    look({30'h1ABCD, 13'h123}, 11'h5A3, h, pa);
    look({30'h2BCDE, 13'h456}, 11'h07F, h, pa);
    rd(2'd2, d); chk("R9 status", d, {47'd0, 11'h5A3, 6'd0} | 64'h11);
    chk("R10 status held", d[16:0] == 17'h168D1 ? 64'd1 : 64'd0, 64'd1);
    rd(2'd3, d); chk("R10 va held (first miss)", d, {21'd0, 30'h1ABCD, 13'h123});
    look({30'h2BCDE, 13'h456}, 11'h07F, h, pa);
    chk("R9 miss no hit", {63'd0, h}, 64'd0);
    rd(2'd2, d); chk("R10 status after unlock", d, {47'd0, 11'h07F, 6'd0} | 64'h11);
    rd(2'd3, d); chk("R9 va after unlock", d, {21'd0, 30'h2BCDE, 13'h456});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule